// File: doc/BRIEF.md
# Video timing signal extractor

This block watches a 10-bit parallel video word stream on the pixel clock. It produces horizontal, vertical and field flags (H, V, F) that line up with a delayed copy of the stream. The flags come from one of two sources, and a mode input picks the source. In embedded mode they come from timing reference sequences carried in the data. In external mode they come from H, V and F levels driven from outside.

A timing reference sequence is four consecutive words: all-ones, zero, zero, then a code word. In the code word the most significant bit is 1, F sits at bit 8, V at bit 7 and H at bit 6. H = 1 marks an end-of-active-video sequence and H = 0 marks a start-of-active-video sequence.

A configuration bit sets how the H flag frames horizontal blanking in embedded mode:
- **Whole-interval framing:** H covers the whole blanking interval, including both reference sequences.
- **Code-bit framing:** H follows the H bit of each code word.

The data path is delayed by four words, so each flag is valid on the same cycle as the output word it describes.

Top module: `vid_timing_extract`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) makes dout zero, h_out, v_out, f_out and trs_found low on the following cycle, and sets the H framing bit to 0.
- R2: dout equals the din word sampled four clock edges earlier.
- R3: A reference sequence is recognised when four consecutive words are 3FFh, 000h, 000h and a code word with bit 9 = 1. trs_found is high for exactly the one cycle in which dout shows the 3FFh word of that sequence, in either mode.
- R4: With detect_trs low, {f_out, v_out, h_out} equal {ext_f, ext_v, ext_h} sampled four edges earlier, whatever the framing bit is.
- R5: With detect_trs high and framing bit 0, h_out goes high on the cycle dout shows the 3FFh word of any recognised sequence.
- R6: With detect_trs high and framing bit 0, h_out stays high while dout shows all four words of a start sequence (code bit 6 = 0). It goes low on the next word and then holds until the next recognised sequence.
- R7: With detect_trs high and framing bit 1, h_out takes code bit 6 on the cycle dout shows that code word, and holds otherwise.
- R8: With detect_trs high, v_out and f_out take code bits 7 and 8 on the cycle dout shows the code word, and change at no other time.
- R9: cfg_hmode is stored into the framing bit at an edge where cfg_we is high. The stored value takes effect from the next edge.
- R10: A 3FFh, 000h, 000h run followed by a word with bit 9 = 0 is not a sequence. It raises no trs_found and leaves h_out, v_out and f_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| detect_trs | input | 1 | 1 = timing from embedded sequences, 0 = external levels |
| cfg_we | input | 1 | Write strobe for the H framing bit |
| cfg_hmode | input | 1 | Framing value: 0 whole blanking interval, 1 code-bit H |
| din | input | DW (10) | Parallel video word |
| ext_h | input | 1 | External horizontal level |
| ext_v | input | 1 | External vertical level |
| ext_f | input | 1 | External field level |
| dout | output | DW (10) | Video word delayed by four edges |
| h_out | output | 1 | Horizontal blanking flag |
| v_out | output | 1 | Vertical blanking flag |
| f_out | output | 1 | Field flag |
| trs_found | output | 1 | Marks the first word of a recognised sequence on dout |

## Verification
The hardest situation to reach is a change of framing bit or source while a sequence is partway through the delay. In that case the pending code word or the start-sequence tail must resolve under the new setting, and after a return to embedded mode the held flags must keep whatever the external path left in them.

The stimulus builds structured lines: end sequence, blanking filler, start sequence, active filler. Filler words never equal 000h or 3FFh, so only the inserted sequences can match. Between lines the source, the framing bit and the external levels are re-drawn at random. Directed cases cover back-to-back end and start sequences, an invalid code word, and a reset in the middle of a run.

// File: rtl/vte_pkg.sv
package vte_pkg;
    // Words in one timing reference sequence; also the data path latency.
    localparam int TRS_LEN = 4;
    localparam int POS_W   = $clog2(TRS_LEN + 1);

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } hvf_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;   // 0 idle, 1..TRS_LEN = word of sequence now on dout
        hvf_t             code;  // flags captured from the latest code word
        hvf_t             flg;   // flags on the outputs
        logic             hcfg;  // H framing: 0 whole interval, 1 code bit
        logic             trs;   // first sequence word on dout
    } eng_state_t;
endpackage

// File: rtl/vte_stage.sv
module vte_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = d;
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/vte_trs_detect.sv
module vte_trs_detect #(
    parameter int DW   = 10,
    parameter int NMID = 2
) (
    input  logic [DW-1:0]            lead,
    input  logic [NMID-1:0][DW-1:0]  mids,
    input  logic                     mark,
    output logic                     hit
);
    always_comb begin
        hit = (lead == {DW{1'b1}}) && mark;
        for (int i = 0; i < NMID; i++) begin
            if (mids[i] != '0) hit = 1'b0;
        end
    end
endmodule

// File: rtl/vte_flag_engine.sv
module vte_flag_engine
    import vte_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic detect,
    input  logic cfg_we,
    input  logic cfg_val,
    input  logic hit,
    input  hvf_t code_in,
    input  hvf_t ext_in,
    output hvf_t flg,
    output logic trs,
    output logic hcfg
);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
    localparam logic [POS_W-1:0] POS_CODE  = POS_W'(TRS_LEN);
    localparam logic [POS_W-1:0] POS_PRE   = POS_W'(TRS_LEN - 1);

    eng_state_t s_d, s_q;
    logic code_due;
    logic sav_done;

    always_comb begin
        s_d      = s_q;
        code_due = !hit && (s_q.pos == POS_PRE);
        sav_done = !hit && (s_q.pos == POS_CODE) && !s_q.code.h;

        s_d.hcfg = cfg_we ? cfg_val : s_q.hcfg;
        s_d.trs  = hit;

        if (hit) begin
            s_d.pos  = POS_FIRST;
            s_d.code = code_in;
        end else if (s_q.pos != '0 && s_q.pos != POS_CODE) begin
            s_d.pos = s_q.pos + POS_W'(1);
        end else begin
            s_d.pos = '0;
        end

        if (!detect) begin
            s_d.flg = ext_in;
        end else begin
            if (!s_q.hcfg) begin
                if (hit)           s_d.flg.h = 1'b1;
                else if (sav_done) s_d.flg.h = 1'b0;
            end else if (code_due) begin
                s_d.flg.h = s_q.code.h;
            end
            if (code_due) begin
                s_d.flg.v = s_q.code.v;
                s_d.flg.f = s_q.code.f;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign flg  = s_q.flg;
    assign trs  = s_q.trs;
    assign hcfg = s_q.hcfg;
endmodule

// File: rtl/vid_timing_extract.sv
module vid_timing_extract
    import vte_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          detect_trs,
    input  logic          cfg_we,
    input  logic          cfg_hmode,
    input  logic [DW-1:0] din,
    input  logic          ext_h,
    input  logic          ext_v,
    input  logic          ext_f,
    output logic [DW-1:0] dout,
    output logic          h_out,
    output logic          v_out,
    output logic          f_out,
    output logic          trs_found
);
    localparam int NW    = TRS_LEN;
    localparam int NMID  = NW - 2;
    localparam int F_BIT = DW - 2;
    localparam int H_BIT = DW - 4;

    logic [NW:0][DW-1:0] dl;    // dl[0] = din, dl[k] = din after k edges
    logic [NW-1:0][2:0]  el;    // external flags, one stage short of dl
    logic                hit_w;
    hvf_t                code_w;
    hvf_t                flg_w;
    logic                trs_w;
    logic                hcfg_w;

    assign dl[0] = din;
    assign el[0] = {ext_f, ext_v, ext_h};

    for (genvar g = 0; g < NW; g++) begin : g_data
        vte_stage #(.W(DW)) u_stage (
            .clk (clk),
            .rst (rst),
            .d   (dl[g]),
            .q   (dl[g+1])
        );
    end

    for (genvar g = 0; g < NW - 1; g++) begin : g_ext
        vte_stage #(.W(3)) u_stage (
            .clk (clk),
            .rst (rst),
            .d   (el[g]),
            .q   (el[g+1])
        );
    end

    // The window examined is the one that will sit in the pipe after this edge.
    assign code_w = hvf_t'(dl[0][F_BIT:H_BIT]);

    vte_trs_detect #(.DW(DW), .NMID(NMID)) u_det (
        .lead (dl[NW-1]),
        .mids (dl[NW-2:1]),
        .mark (dl[0][DW-1]),
        .hit  (hit_w)
    );

    vte_flag_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .detect  (detect_trs),
        .cfg_we  (cfg_we),
        .cfg_val (cfg_hmode),
        .hit     (hit_w),
        .code_in (code_w),
        .ext_in  (hvf_t'(el[NW-1])),
        .flg     (flg_w),
        .trs     (trs_w),
        .hcfg    (hcfg_w)
    );

    assign dout      = dl[NW];
    assign h_out     = flg_w.h;
    assign v_out     = flg_w.v;
    assign f_out     = flg_w.f;
    assign trs_found = trs_w;
endmodule

// File: rtl/vte_checker.sv
module vte_checker #(
    parameter int DW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          detect_trs,
    input logic [DW-1:0] din,
    input logic          ext_h,
    input logic          ext_v,
    input logic          ext_f,
    input logic [DW-1:0] dout,
    input logic          h_out,
    input logic          v_out,
    input logic          f_out,
    input logic          trs_found,
    input logic          hcfg
);
    logic [2:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)               cyc_q <= '0;
        else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dout == '0 && !h_out && !v_out && !f_out && !trs_found && !hcfg));

    assert_data_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4) |-> (dout == $past(din, 4)));

    assert_trs_pattern_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4 && trs_found) |->
            (dout == {DW{1'b1}} && $past(din, 3) == '0 && $past(din, 2) == '0
             && $past(din[DW-1], 1)));

    assert_trs_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        trs_found |=> !trs_found);

    assert_ext_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4 && !$past(detect_trs)) |->
            ({f_out, v_out, h_out} == {$past(ext_f, 4), $past(ext_v, 4), $past(ext_h, 4)}));

    assert_h_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd2 && $past(detect_trs) && !$past(hcfg) && $rose(h_out)) |-> trs_found);

    assert_h_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd5 && $past(detect_trs) && !$past(hcfg) && $fell(h_out)) |->
            $past(trs_found, 4));

    assert_h_code_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4 && $past(detect_trs) && $past(hcfg) && !$stable(h_out)) |->
            $past(trs_found, 3));

    assert_vf_code_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd4 && $past(detect_trs) && (!$stable(v_out) || !$stable(f_out))) |->
            $past(trs_found, 3));
endmodule

bind vid_timing_extract vte_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .detect_trs (detect_trs),
    .din        (din),
    .ext_h      (ext_h),
    .ext_v      (ext_v),
    .ext_f      (ext_f),
    .dout       (dout),
    .h_out      (h_out),
    .v_out      (v_out),
    .f_out      (f_out),
    .trs_found  (trs_found),
    .hcfg       (hcfg_w)
);

// File: tb/vid_timing_extract_tb.sv
`timescale 1ns/1ps
module vid_timing_extract_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       detect_trs = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_hmode = 1'b0;
    logic [9:0] din = '0;
    logic       ext_h = 1'b0, ext_v = 1'b0, ext_f = 1'b0;
    logic [9:0] dout;
    logic       h_out, v_out, f_out, trs_found;

    always #2.5 clk = ~clk;

    vid_timing_extract u_dut (
        .clk(clk), .rst(rst), .detect_trs(detect_trs), .cfg_we(cfg_we),
        .cfg_hmode(cfg_hmode), .din(din), .ext_h(ext_h), .ext_v(ext_v),
        .ext_f(ext_f), .dout(dout), .h_out(h_out), .v_out(v_out),
        .f_out(f_out), .trs_found(trs_found)
    );

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    // reference model state
    logic [9:0] wh [4];
    logic [2:0] xh [4];
    logic       hq [5];
    logic [2:0] cq [5];
    logic       mhcfg;
    logic       eh, ev, ef, etrs;
    logic [9:0] edout;

    function automatic logic [9:0] filler();
        return 10'(4 + ($urandom % 1016));
    endfunction

    function automatic logic [9:0] code_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, 6'($urandom % 64)};
    endfunction

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        nfail++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin wh[k] = '0; xh[k] = '0; end
        for (int k = 0; k < 5; k++) begin hq[k] = 1'b0; cq[k] = '0; end
        mhcfg = 1'b0; eh = 0; ev = 0; ef = 0; etrs = 0; edout = '0;
    endtask

    task automatic model_step(input logic [9:0] w, input logic [2:0] ex,
                              input logic det, input logic we, input logic cv);
        logic hc;
        hc = mhcfg;
        for (int k = 3; k > 0; k--) begin wh[k] = wh[k-1]; xh[k] = xh[k-1]; end
        wh[0] = w; xh[0] = ex;
        for (int k = 4; k > 0; k--) begin hq[k] = hq[k-1]; cq[k] = cq[k-1]; end
        hq[0] = (wh[3] == 10'h3FF) && (wh[2] == 10'h000) && (wh[1] == 10'h000) && wh[0][9];
        cq[0] = wh[0][8:6];
        edout = wh[3];
        etrs  = hq[0];
        if (det) begin
            if (!hc) begin
                if (hq[0]) eh = 1'b1;
                else if (hq[4] && !cq[4][0]) eh = 1'b0;
            end else if (hq[3]) begin
                eh = cq[3][0];
            end
            if (hq[3]) begin ef = cq[3][2]; ev = cq[3][1]; end
        end else begin
            {ef, ev, eh} = xh[3];
        end
        if (we) mhcfg = cv;
    endtask

    task automatic step(input logic [9:0] w, input logic [2:0] ex, input logic det,
                        input logic we, input logic cv, input logic r, input string tag);
        string hreq;
        din = w; {ext_f, ext_v, ext_h} = ex; detect_trs = det;
        cfg_we = we; cfg_hmode = cv; rst = r;
        hreq = det ? (mhcfg ? "R7" : "R6") : "R4";
        @(posedge clk);
        #1;
        if (r) model_reset();
        else   model_step(w, ex, det, we, cv);
        nvec++;
        if (dout !== edout)     fail_line({tag, " R2"}, "dout", int'(dout), int'(edout));
        if (trs_found !== etrs) fail_line({tag, " R3"}, "trs_found", int'(trs_found), int'(etrs));
        if (h_out !== eh)       fail_line({tag, " ", hreq}, "h_out", int'(h_out), int'(eh));
        if (v_out !== ev)       fail_line({tag, det ? " R8" : " R4"}, "v_out", int'(v_out), int'(ev));
        if (f_out !== ef)       fail_line({tag, det ? " R8" : " R4"}, "f_out", int'(f_out), int'(ef));
        @(negedge clk);
    endtask

    task automatic put_trs(input logic [9:0] cw, input logic det, input string tag);
        step(10'h3FF, 3'($urandom % 8), det, 1'b0, 1'b0, 1'b0, tag);
        step(10'h000, 3'($urandom % 8), det, 1'b0, 1'b0, 1'b0, tag);
        step(10'h000, 3'($urandom % 8), det, 1'b0, 1'b0, 1'b0, tag);
        step(cw,      3'($urandom % 8), det, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic put_fill(input int n, input logic det, input string tag);
        for (int i = 0; i < n; i++)
            step(filler(), 3'($urandom % 8), det, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic put_line(input logic det, input int nblank, input int nact, input string tag);
        logic f, v;
        f = 1'($urandom % 2); v = 1'($urandom % 2);
        put_trs(code_word(f, v, 1'b1), det, tag);
        put_fill(nblank, det, tag);
        put_trs(code_word(f, v, 1'b0), det, tag);
        put_fill(nact, det, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        model_reset();
        @(negedge clk);
        // R1: reset state, with a config write attempted during reset
        for (int i = 0; i < 3; i++) step(10'h155, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, "R1");
        put_fill(6, 1'b1, "R1");

        // R5 / R6: whole-interval framing in embedded mode
        put_line(1'b1, 3, 8, "R5");
        put_line(1'b1, 0, 5, "R6");
        // back-to-back end and start sequences
        put_trs(code_word(1'b1, 1'b1, 1'b1), 1'b1, "R6");
        put_trs(code_word(1'b1, 1'b0, 1'b0), 1'b1, "R6");
        put_fill(6, 1'b1, "R6");

        // R10: invalid code word (bit 9 = 0) is ignored
        put_trs(10'h1C0, 1'b1, "R10");
        put_fill(6, 1'b1, "R10");

        // R9: switch to code-bit framing; R7 / R8 follow
        step(filler(), 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        put_line(1'b1, 4, 6, "R7");
        put_line(1'b1, 1, 4, "R8");
        put_trs(10'h040, 1'b1, "R10");
        put_fill(5, 1'b1, "R10");

        // R4: external source, framing bit has no effect
        put_line(1'b0, 3, 6, "R4");
        step(filler(), 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        put_line(1'b0, 2, 6, "R4");

        // random mix
        for (int ln = 0; ln < 180; ln++) begin
            logic det;
            det = 1'($urandom % 3 != 0);
            if ($urandom % 4 == 0)
                step(filler(), 3'($urandom % 8), det, 1'b1, 1'($urandom % 2), 1'b0, "R9");
            put_line(det, int'($urandom % 6), int'(1 + $urandom % 14), "RND");
            if ($urandom % 8 == 0) begin
                // switch source or framing in the middle of a sequence
                put_trs(code_word(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2)), det, "RND");
                step(filler(), 3'($urandom % 8), !det, 1'b1, 1'($urandom % 2), 1'b0, "RND");
                put_fill(3, !det, "RND");
            end
        end

        // R1: reset in mid-run, then framing bit back to 0
        put_trs(code_word(1'b1, 1'b1, 1'b1), 1'b1, "R1");
        step(10'h3FF, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        put_fill(4, 1'b1, "R1");
        put_line(1'b1, 2, 4, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule